// File: doc/BRIEF.md
# Programmable Interval Timer with Level and Periodic Interrupts

This block is an 8-bit binary down-counter with a preset, a choice of four tick sources, a sticky event flag and an active-low interrupt request. A host programs it through a small register port and chooses between two modes. In level mode the timer stops when it reaches zero and the interrupt stays asserted until the flag is cleared. In periodic mode the interrupt is a pulse, and the counter reloads from the preset to run again.

The tick sources are single-cycle enables from an outside prescaler, nominally 4096 Hz, 64 Hz, 1 Hz and one per minute. A fifth enable at the 32.768 kHz reference times how long the periodic interrupt pulse lasts. The interrupt pin is modelled as open-drain: `irqOe` high means the pin is pulled low, and `irqN` is its logic level.

Top module: `pit_timer`

## Requirements
- R1: After reset the preset, the count, the setup register and the status register all read 0, and the interrupt is released (`irqOe`=0, `irqN`=1).
- R2: The register map is as follows. Address 0 is the preset and can be read and written; a write to it loads the counter in the same cycle. Address 1 reads the live count, and writes to it are ignored. Address 2 is setup: bit 3 run, bit 2 periodic mode, bits 1:0 source. Address 3 is status: bit 1 flag, bit 0 interrupt enable. The preset keeps its value until it is written again.
- R3: Source code 00 selects `tickFast`, 01 `tickMid`, 10 `tickSec` and 11 `tickMin`. Only the selected tick decrements the count.
- R4: The count moves only while run is 1. Clearing run halts it where it is. Setting run and then clearing it with no selected tick in between leaves the count unchanged.
- R5: The flag becomes 1 when a decrement takes the count from 1 to 0. It then holds until a write to status puts 0 in bit 1. Writing 1 to bit 1 never sets the flag.
- R6: `irqOe` can be 1 only while the interrupt enable is 1. With the enable at 0 the line stays released even if the flag is 1.
- R7: In level mode, reaching zero clears run, the count stays at 0, and `irqOe` equals enable AND flag, so it releases when the flag is cleared.
- R8: In level mode, if run was set while the flag was already 1, run stays 1 after the count reaches zero.
- R9: In periodic mode with source 00, the zero event drives the line for RET_FAST reference ticks and then releases it. At that release the count reloads from the preset and the flag stays 1. Source ticks are ignored during this window.
- R10: In periodic mode with any other source, the release window lasts RET_SLOW reference ticks.
- R11: With run at 1 and a count of zero, source ticks produce no flag and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| addr | input | 2 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| tickFast | input | 1 | 4096 Hz tick enable |
| tickMid | input | 1 | 64 Hz tick enable |
| tickSec | input | 1 | 1 Hz tick enable |
| tickMin | input | 1 | Once-per-minute tick enable |
| tickRef | input | 1 | 32.768 kHz reference enable for pulse timing |
| irqN | output | 1 | Interrupt pin level, low when asserted |
| irqOe | output | 1 | Pull-down enable of the open-drain pin |

## Verification
The bench builds the block with DATA_W=8 and RET_FAST=4, and with RET_SLOW lowered from 256 to 32. The shorter slow window lets the bench count both periodic release windows edge by edge within a few hundred cycles. Because every tick enable is a bench input, level-mode runs can be driven with random noise on the unselected sources. Expected counts and flags are derived only from how many selected ticks were applied.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef struct packed {
    logic loadPreset;
    logic dec;
    logic reload;
  } pit_strobe_t;

  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_MID  = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_MIN  = 2'b11
  } pit_src_e;

  localparam logic [1:0] ADDR_PRESET = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_SETUP  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pit_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] preset,
  output logic [DATA_W-1:0] count,
  output logic              countZero,
  output logic              countOne
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preset <= '0;
      count  <= '0;
    end else if (strobe.loadPreset) begin
      preset <= wrData;
      count  <= wrData;
    end else if (strobe.reload) begin
      count <= preset;
    end else if (strobe.dec) begin
      count <= count - ONE;
    end
  end

  assign countZero = (count == '0);
  assign countOne  = (count == ONE);
endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RET_FAST = 4,
  parameter int RET_SLOW = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        srcTicks,
  input  logic              tickRef,
  input  logic              countZero,
  input  logic              countOne,
  output pit_strobe_t       strobe,
  output logic              runEn,
  output logic              periodic,
  output pit_src_e          src,
  output logic              flag,
  output logic              irqEn,
  output logic              irqOe
);
  localparam int RW = (RET_SLOW > 1) ? $clog2(RET_SLOW) : 1;
  localparam logic [RW-1:0] LIM_FAST = RW'(RET_FAST - 1);
  localparam logic [RW-1:0] LIM_SLOW = RW'(RET_SLOW - 1);

  logic          startedWithFlag;
  logic          pulseActive;
  logic [RW-1:0] retCnt;
  logic [RW-1:0] retLimit;
  logic          wrSetup, wrStatus, wrPreset;
  logic          tickSel, step, hit, retDone;

  assign wrPreset = wrEn && (addr == ADDR_PRESET);
  assign wrSetup  = wrEn && (addr == ADDR_SETUP);
  assign wrStatus = wrEn && (addr == ADDR_STATUS);

  assign tickSel  = srcTicks[src];
  assign step     = runEn && tickSel && !countZero && !pulseActive && !wrPreset;
  assign hit      = step && countOne;
  assign retLimit = (src == SRC_FAST) ? LIM_FAST : LIM_SLOW;
  assign retDone  = pulseActive && tickRef && (retCnt == retLimit);

  always_comb begin
    strobe.loadPreset = wrPreset;
    strobe.dec        = step;
    strobe.reload     = retDone && runEn && periodic && !wrPreset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn           <= 1'b0;
      periodic        <= 1'b0;
      src             <= SRC_FAST;
      startedWithFlag <= 1'b0;
    end else if (wrSetup) begin
      runEn    <= wrData[3];
      periodic <= wrData[2];
      src      <= pit_src_e'(wrData[1:0]);
      if (wrData[3] && !runEn) startedWithFlag <= flag;
    end else if (hit && !periodic && !startedWithFlag) begin
      runEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag  <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (hit) flag <= 1'b1;
      else if (wrStatus && !wrData[1]) flag <= 1'b0;
      if (wrStatus) irqEn <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      retCnt      <= '0;
    end else if (hit && periodic) begin
      pulseActive <= 1'b1;
      retCnt      <= '0;
    end else if (retDone) begin
      pulseActive <= 1'b0;
    end else if (pulseActive && tickRef) begin
      retCnt <= retCnt + RW'(1);
    end
  end

  assign irqOe = periodic ? (irqEn && flag && pulseActive) : (irqEn && flag);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RET_FAST = 4,
  parameter int RET_SLOW = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickFast,
  input  logic              tickMid,
  input  logic              tickSec,
  input  logic              tickMin,
  input  logic              tickRef,
  output logic              irqN,
  output logic              irqOe
);
  pit_strobe_t       strobe;
  logic [DATA_W-1:0] preset, count;
  logic              countZero, countOne;
  logic              runEn, periodic, flag, irqEn;
  pit_src_e          src;

  pit_control #(.DATA_W(DATA_W), .RET_FAST(RET_FAST), .RET_SLOW(RET_SLOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .srcTicks({tickMin, tickSec, tickMid, tickFast}), .tickRef(tickRef),
    .countZero(countZero), .countOne(countOne), .strobe(strobe),
    .runEn(runEn), .periodic(periodic), .src(src), .flag(flag),
    .irqEn(irqEn), .irqOe(irqOe)
  );

  pit_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .preset(preset), .count(count), .countZero(countZero), .countOne(countOne)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_PRESET: rdData = preset;
      ADDR_COUNT:  rdData = count;
      ADDR_SETUP:  rdData[3:0] = {runEn, periodic, src};
      default:     rdData[1:0] = {flag, irqEn};
    endcase
  end

  assign irqN = ~irqOe;
endmodule

// File: rtl/pit_timer_checker.sv
module pit_timer_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic              runEn,
  input logic              flag,
  input logic              irqEn,
  input logic              irqOe,
  input logic [DATA_W-1:0] count
);
  // R6: the line is pulled only with enable and flag both set
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOe |-> (irqEn && flag));

  // R4: with run off and no write the count does not move
  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrEn) |=> $stable(count));

  // R5: the flag rises only when the counter has just reached zero
  p_flag_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> (count == '0));

  // R5: the flag stays set unless a status write clears it
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(wrEn && addr == 2'd3 && !wrData[1])) |=> flag);
endmodule

bind pit_timer pit_timer_checker #(.DATA_W(DATA_W)) u_pit_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .runEn(runEn), .flag(flag), .irqEn(irqEn), .irqOe(irqOe), .count(count)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
  localparam int W = 8;
  localparam int RF = 4;
  localparam int RS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic [4:0] tickVec = '0;
  logic irqN, irqOe;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_timer #(.DATA_W(W), .RET_FAST(RF), .RET_SLOW(RS)) i_pit_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .tickFast(tickVec[0]), .tickMid(tickVec[1]), .tickSec(tickVec[2]), .tickMin(tickVec[3]),
    .tickRef(tickVec[4]), .irqN(irqN), .irqOe(irqOe)
  );

  function automatic int expCount(int p, int n);
    return (n >= p) ? 0 : p - n;
  endfunction

  function automatic int expFlag(int p, int n);
    return (p > 0 && n >= p) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdData);
  endtask

  task automatic tick(int idx, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickVec[idx] = 1'b1;
      @(negedge clk); tickVec[idx] = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int v;
    int unsigned seed;
    seed = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(0, v); check("R1 preset", v, 0);
    rd(1, v); check("R1 count", v, 0);
    rd(2, v); check("R1 setup", v, 0);
    rd(3, v); check("R1 status", v, 0);
    check("R1 irqOe", int'(irqOe), 0);
    check("R1 irqN", int'(irqN), 1);

    // R2 preset loads count; count address ignores writes
    wr(0, 5);
    rd(1, v); check("R2 count load", v, 5);
    wr(1, 9);
    rd(1, v); check("R2 count write ignored", v, 5);

    // R4 no counting while stopped
    tick(1, 2);
    rd(1, v); check("R4 idle", v, 5);

    // R3 source 01 only
    wr(2, 8'h9);
    tick(0, 2); tick(2, 1); tick(3, 1);
    rd(1, v); check("R3 other sources ignored", v, 5);
    tick(1, 3);
    rd(1, v); check("R3 mid source counts", v, 2);

    // R4 halt, and start-stop without a tick
    wr(2, 8'h1);
    tick(1, 2);
    rd(1, v); check("R4 halted", v, 2);
    wr(2, 8'h9); wr(2, 8'h1);
    rd(1, v); check("R4 short start-stop", v, 2);
    rd(0, v); check("R2 preset kept", v, 5);

    // R5/R7 level run to zero
    wr(2, 8'h9);
    tick(1, 2);
    rd(1, v); check("R7 count zero", v, 0);
    rd(3, v); check("R5 flag set", v, 2);
    rd(2, v); check("R7 run cleared", v, 1);
    check("R6 no drive without enable", int'(irqOe), 0);
    wr(3, 8'h3);
    check("R7 line low", int'(irqN), 0);
    tick(1, 2);
    rd(1, v); check("R7 stays at zero", v, 0);

    // R8 start with flag already set
    wr(0, 2);
    wr(2, 8'h9);
    tick(1, 2);
    rd(1, v); check("R8 count zero", v, 0);
    rd(2, v); check("R8 run kept", v, 9);
    wr(3, 8'h1);
    rd(3, v); check("R7 flag cleared", v, 1);
    check("R7 released on clear", int'(irqOe), 0);
    wr(3, 8'h3);
    rd(3, v); check("R5 write one ignored", v, 1);
    wr(2, 8'h0);

    // R9 periodic, fast source
    wr(0, 3);
    wr(2, 8'hC);
    tick(0, 3);
    check("R9 pulse on", int'(irqOe), 1);
    tick(0, 1);
    rd(1, v); check("R9 held in window", v, 0);
    tick(4, RF - 1);
    check("R9 still on", int'(irqOe), 1);
    tick(4, 1);
    check("R9 released", int'(irqOe), 0);
    rd(1, v); check("R9 reloaded", v, 3);
    rd(3, v); check("R9 flag kept", v, 3);
    tick(0, 1);
    rd(1, v); check("R9 continues", v, 2);

    // R10 periodic, slow source
    wr(2, 8'h0); wr(3, 8'h1); wr(0, 1);
    wr(2, 8'hE);
    tick(2, 1);
    check("R10 pulse on", int'(irqOe), 1);
    tick(4, RS - 1);
    check("R10 still on", int'(irqOe), 1);
    tick(4, 1);
    check("R10 released", int'(irqOe), 0);
    rd(1, v); check("R10 reloaded", v, 1);

    // R6 periodic with enable off
    wr(3, 8'h0);
    tick(2, 1);
    rd(3, v); check("R6 flag set", v, 2);
    check("R6 line released", int'(irqOe), 0);
    tick(4, RS);

    // R11 zero preset
    wr(2, 8'h0); wr(3, 8'h1); wr(0, 0);
    wr(2, 8'hC);
    tick(0, 5);
    rd(3, v); check("R11 no flag", v, 1);
    check("R11 no irq", int'(irqOe), 0);

    // random level-mode runs (R3, R5, R7)
    for (int it = 0; it < 24; it++) begin
      int p, n, s, ie;
      p  = 1 + int'($urandom % 20);
      s  = int'($urandom % 4);
      ie = int'($urandom % 2);
      n  = 0;
      wr(2, 8'h0); wr(3, 8'h0);
      wr(0, W'(p));
      wr(3, W'(ie));
      wr(2, W'(8 | s));
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        tickVec = {1'b0, 4'($urandom)};
        if (tickVec[s]) n++;
      end
      @(negedge clk); tickVec = '0;
      rd(1, v); check("R3 random count", v, expCount(p, n));
      rd(3, v); check("R5 random flag", v, expFlag(p, n) * 2 + ie);
      rd(2, v); check("R7 random run", v, (expFlag(p, n) ? 0 : 8) | s);
      check("R7 random line", int'(irqOe), expFlag(p, n) & ie);
    end

    done = 1'b1;
    finishRun();
  end
endmodule